// File: doc/BRIEF.md
# Serial Bus Pause Controller

This block lets a host pause a serial slave interface in the middle of a transfer without deselecting it. It watches the chip select (active low), the serial clock, an active-low pause input and the quad-enable configuration bit. All four are sampled by a faster system clock through a synchronizer chain. From them it keeps a small state machine and drives four outputs:

- a pause flag, which freezes the slave's shift engine (bit counter and partial byte) and tri-states its data output;
- a transfer-enable flag, high while shifting is allowed;
- a lockout flag;
- a fixed-width reset pulse for the slave interface logic.

Entry into the paused state is taken only while the serial clock is low. If the pause input changes while the clock is high, the request waits until the clock goes low. Exit follows the same rule. When quad mode is enabled the pause input serves as a data lane, so the pause function is switched off entirely.

Deselecting the slave while paused emits the interface reset pulse and enters a lockout state. Communication restarts only after the pause input has returned high with the slave deselected, and chip select is then driven low again. Program, erase or status-write operations already running inside the slave are not routed through this block and are never stopped by it.

Top module: `spi_pause_ctrl`

## Requirements
- R1: After reset, `hold_o`, `xfer_en_o`, `lockout_o` and `iface_rst_o` are all 0.
- R2: With chip select low, `quad_en_i`=0, and the bus running (`xfer_en_o`=1), `pause_n_i`=0 together with `sclk_i`=0 sets `hold_o`=1 and `xfer_en_o`=0. The change appears after exactly SYNC_STAGES+1 rising system-clock edges.
- R3: If `pause_n_i` falls while `sclk_i`=1, `hold_o` stays 0 and `xfer_en_o` stays 1 until `sclk_i` goes low; `hold_o` then becomes 1.
- R4: If `pause_n_i` returns high before `sclk_i` goes low, the pending entry is dropped and `hold_o` never becomes 1.
- R5: While paused, `pause_n_i`=1 with `sclk_i`=0 clears `hold_o` and sets `xfer_en_o`. With `sclk_i`=1 the exit waits until the clock goes low.
- R6: With `quad_en_i`=1, `pause_n_i` is ignored (`hold_o` stays 0). Raising `quad_en_i` while paused releases the pause and resumes the transfer.
- R7: With chip select high (`cs_n_i`=1) and no lockout, `pause_n_i` has no effect: `hold_o` and `xfer_en_o` stay 0 and no reset pulse occurs.
- R8: Raising `cs_n_i` while paused sets `lockout_o`=1, clears `hold_o`, and emits exactly one `iface_rst_o` pulse of RST_PULSE_CYC system-clock cycles.
- R9: `lockout_o` clears only when `cs_n_i`=1 and `pause_n_i`=1 at the same time. While `lockout_o`=1, `xfer_en_o` stays 0 even with chip select low. After the lockout clears, a new chip-select fall sets `xfer_en_o`=1.
- R10: Raising `cs_n_i` while not paused, including while an entry is still waiting for the clock to go low, produces no `iface_rst_o` pulse and no lockout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs_n_i | input | 1 | Slave chip select, active low |
| sclk_i | input | 1 | Serial bus clock |
| pause_n_i | input | 1 | Active-low pause request |
| quad_en_i | input | 1 | Quad mode enable; 1 turns off the pause function |
| hold_o | output | 1 | Paused: freeze shift engine and tri-state data output |
| xfer_en_o | output | 1 | Shift engine may run |
| lockout_o | output | 1 | Interface locked after a deselect during a pause |
| iface_rst_o | output | 1 | Reset pulse for the slave interface logic |

## Verification
The bench builds the block with SYNC_STAGES=2 and RST_PULSE_CYC=4, the default values. With the short synchronizer chain, the exact entry latency of R2 is checked at a known edge count. The four-cycle pulse ends well inside every settling window, so each pulse's width and count can be compared exactly. Random steps mix clock-high deferrals, aborted entries, quad-mode changes and deselects during a pause, and compare the outputs against a settled-state model after every step.

// File: rtl/spause_pkg.sv
package spause_pkg;

  typedef enum logic [2:0] {
    SP_IDLE       = 3'd0,
    SP_RUN        = 3'd1,
    SP_ENTER_WAIT = 3'd2,
    SP_HELD       = 3'd3,
    SP_EXIT_WAIT  = 3'd4,
    SP_LOCKOUT    = 3'd5
  } sp_state_e;

  typedef struct packed {
    logic cs_n;
    logic sclk;
    logic pause_n;
    logic qe;
  } sp_in_t;

  localparam int SP_IN_W = $bits(sp_in_t);
  localparam sp_in_t SP_IN_RST = '{cs_n: 1'b1, sclk: 1'b0, pause_n: 1'b1, qe: 1'b0};

endpackage

// File: rtl/spause_sync.sv
module spause_sync #(
  parameter int            STAGES  = 2,
  parameter int            W       = 4,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] chain_q;
  logic [STAGES-1:0][W-1:0] chain_d;

  always_comb begin
    chain_d[0] = d_i;
    for (int i = 1; i < STAGES; i++) begin
      chain_d[i] = chain_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= {STAGES{RST_VAL}};
    end else begin
      chain_q <= chain_d;
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/spause_fsm.sv
module spause_fsm
  import spause_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  sp_in_t in_s,
  output logic   hold_o,
  output logic   xfer_en_o,
  output logic   lock_o,
  output logic   lock_enter_o
);
  sp_state_e state_q, state_d;
  logic cs_act, hold_req, sck_low;

  assign cs_act   = ~in_s.cs_n;
  assign hold_req = ~in_s.pause_n & ~in_s.qe;
  assign sck_low  = ~in_s.sclk;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SP_IDLE: begin
        if (cs_act) state_d = SP_RUN;
      end
      SP_RUN: begin
        if (!cs_act)       state_d = SP_IDLE;
        else if (hold_req) state_d = sck_low ? SP_HELD : SP_ENTER_WAIT;
      end
      SP_ENTER_WAIT: begin
        if (!cs_act)        state_d = SP_IDLE;
        else if (!hold_req) state_d = SP_RUN;
        else if (sck_low)   state_d = SP_HELD;
      end
      SP_HELD: begin
        if (!cs_act)           state_d = SP_LOCKOUT;
        else if (in_s.qe)      state_d = SP_RUN;
        else if (in_s.pause_n) state_d = sck_low ? SP_RUN : SP_EXIT_WAIT;
      end
      SP_EXIT_WAIT: begin
        if (!cs_act)            state_d = SP_LOCKOUT;
        else if (in_s.qe)       state_d = SP_RUN;
        else if (!in_s.pause_n) state_d = SP_HELD;
        else if (sck_low)       state_d = SP_RUN;
      end
      SP_LOCKOUT: begin
        if (!cs_act && in_s.pause_n) state_d = SP_IDLE;
      end
      default: state_d = SP_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SP_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  assign hold_o       = (state_q == SP_HELD) || (state_q == SP_EXIT_WAIT);
  assign xfer_en_o    = (state_q == SP_RUN) || (state_q == SP_ENTER_WAIT);
  assign lock_o       = (state_q == SP_LOCKOUT);
  assign lock_enter_o = (state_d == SP_LOCKOUT) && (state_q != SP_LOCKOUT);

  // R3: a pause only begins from a sample with the serial clock low
  assert_entry_sclk_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_o) |-> $past(in_s.sclk) == 1'b0);

  // R5: a normal release (no deselect, no quad mode) also waits for clock low
  assert_exit_sclk_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(hold_o) && !lock_o && !$past(in_s.qe)) |-> $past(in_s.sclk) == 1'b0);

  // R6: quad mode leaves the block not paused on the following cycle
  assert_quad_blocks_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_s.qe |=> !hold_o);

  // R8: deselect while paused leads into lockout
  assert_deselect_locks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_o && in_s.cs_n) |=> lock_o);

  // R9: lockout is left only with deselect and pause input high together
  assert_lock_exit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock_o) |-> ($past(in_s.cs_n) && $past(in_s.pause_n)));

  // R9: the three modes are exclusive
  assert_modes_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hold_o, xfer_en_o, lock_o}));
endmodule

// File: rtl/spause_pulse.sv
module spause_pulse #(
  parameter int WIDTH_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_i,
  output logic pulse_o
);
  localparam int CW = $clog2(WIDTH_CYC + 1);
  localparam logic [CW-1:0] LOAD_VAL = CW'(WIDTH_CYC);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = trig_i || (cnt_q != '0);
    cnt_d  = trig_i ? LOAD_VAL : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign pulse_o = (cnt_q != '0);

  // checker state: length of the current pulse so far
  logic [CW:0] len_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q <= '0;
    end else if (pulse_o) begin
      len_q <= len_q + 1'b1;
    end else begin
      len_q <= '0;
    end
  end

  // R8: a pulse never lasts longer than the configured width
  assert_pulse_width_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_o |-> (len_q < (CW+1)'(WIDTH_CYC)));

  // R8: a trigger starts the pulse on the next cycle
  assert_pulse_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    trig_i |=> pulse_o);
endmodule

// File: rtl/spi_pause_ctrl.sv
module spi_pause_ctrl
  import spause_pkg::*;
#(
  parameter int SYNC_STAGES   = 2,
  parameter int RST_PULSE_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n_i,
  input  logic sclk_i,
  input  logic pause_n_i,
  input  logic quad_en_i,
  output logic hold_o,
  output logic xfer_en_o,
  output logic lockout_o,
  output logic iface_rst_o
);
  // asynchronous assertion, synchronous release
  logic [1:0] rst_pipe_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_pipe_q[1];

  sp_in_t raw_in, sync_in;
  logic   lock_enter;

  assign raw_in = '{cs_n: cs_n_i, sclk: sclk_i, pause_n: pause_n_i, qe: quad_en_i};

  spause_sync #(
    .STAGES (SYNC_STAGES),
    .W      (SP_IN_W),
    .RST_VAL(SP_IN_RST)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_int_n),
    .d_i  (raw_in),
    .q_o  (sync_in)
  );

  spause_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .in_s        (sync_in),
    .hold_o      (hold_o),
    .xfer_en_o   (xfer_en_o),
    .lock_o      (lockout_o),
    .lock_enter_o(lock_enter)
  );

  spause_pulse #(
    .WIDTH_CYC(RST_PULSE_CYC)
  ) u_pulse (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .trig_i (lock_enter),
    .pulse_o(iface_rst_o)
  );

  // R10: a reset pulse only starts together with the lockout
  assert_pulse_with_lock_R10: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(iface_rst_o) |-> $rose(lockout_o));
endmodule

// File: tb/tb_spi_pause_ctrl.sv
module tb_spi_pause_ctrl;
  localparam int SYNC_STAGES   = 2;
  localparam int RST_PULSE_CYC = 4;
  localparam int M_IDLE = 0, M_RUN = 1, M_HELD = 2, M_LOCK = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b0, pause_n = 1'b1, qe = 1'b0;
  logic hold, xfer_en, lockout, iface_rst;

  int checks = 0, fails = 0;
  int pulses = 0, last_len = 0, cur_len = 0;
  int model_mode = M_IDLE, model_pulses = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  spi_pause_ctrl #(.SYNC_STAGES(SYNC_STAGES), .RST_PULSE_CYC(RST_PULSE_CYC)) dut (
    .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .sclk_i(sclk), .pause_n_i(pause_n),
    .quad_en_i(qe), .hold_o(hold), .xfer_en_o(xfer_en), .lockout_o(lockout),
    .iface_rst_o(iface_rst));

  // pulse monitor
  always @(negedge clk) begin
    if (iface_rst) cur_len++;
    else if (cur_len != 0) begin
      last_len = cur_len;
      pulses++;
      cur_len = 0;
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic outs(input string req, input int h, input int x, input int l);
    check(req, "hold_o", int'(hold), h);
    check(req, "xfer_en_o", int'(xfer_en), x);
    check(req, "lockout_o", int'(lockout), l);
  endtask

  task automatic settle();
    repeat (12) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drive(input logic c, input logic s, input logic p, input logic q);
    @(negedge clk);
    cs_n = c; sclk = s; pause_n = p; qe = q;
    settle();
  endtask

  // settled-state reference: one transition with stable inputs
  function automatic int model_step(input int m, input logic c, input logic s,
                                    input logic p, input logic q);
    case (m)
      M_IDLE: return c ? M_IDLE : M_RUN;
      M_RUN: begin
        if (c) return M_IDLE;
        if (!q && !p && !s) return M_HELD;
        return M_RUN;
      end
      M_HELD: begin
        if (c) return M_LOCK;
        if (q) return M_RUN;
        if (p && !s) return M_RUN;
        return M_HELD;
      end
      default: return (c && p) ? M_IDLE : M_LOCK;
    endcase
  endfunction

  task automatic model_settle();
    for (int i = 0; i < 4; i++) begin
      int nm;
      nm = model_step(model_mode, cs_n, sclk, pause_n, qe);
      if (nm == M_LOCK && model_mode != M_LOCK) model_pulses++;
      model_mode = nm;
    end
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("test done: total=%0d bad=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int p0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    settle();
    // R1 reset state
    outs("R1", 0, 0, 0);
    check("R1", "iface_rst_o", int'(iface_rst), 0);

    // R7 pause while deselected has no effect
    drive(1, 0, 0, 0);
    outs("R7", 0, 0, 0);
    check("R7", "pulses", pulses, 0);

    // select, run
    drive(0, 0, 1, 0);
    outs("R2", 0, 1, 0);

    // R2 entry with exact latency
    @(negedge clk);
    pause_n = 1'b0;
    repeat (SYNC_STAGES) @(posedge clk);
    @(negedge clk);
    check("R2", "hold_o before latency", int'(hold), 0);
    @(posedge clk);
    @(negedge clk);
    check("R2", "hold_o at latency", int'(hold), 1);
    check("R2", "xfer_en_o at latency", int'(xfer_en), 0);

    // R5 exit deferred while clock high, then taken
    drive(0, 1, 0, 0);
    drive(0, 1, 1, 0);
    outs("R5", 1, 0, 0);
    drive(0, 0, 1, 0);
    outs("R5", 0, 1, 0);

    // R3 entry deferred while clock high
    drive(0, 1, 0, 0);
    outs("R3", 0, 1, 0);
    drive(0, 0, 0, 0);
    outs("R3", 1, 0, 0);
    drive(0, 0, 1, 0);
    outs("R3", 0, 1, 0);

    // R4 pending entry dropped
    drive(0, 1, 0, 0);
    drive(0, 1, 1, 0);
    drive(0, 0, 1, 0);
    outs("R4", 0, 1, 0);

    // R6 quad mode
    drive(0, 0, 0, 1);
    outs("R6", 0, 1, 0);
    drive(0, 0, 0, 0);
    outs("R6", 1, 0, 0);
    drive(0, 0, 0, 1);
    outs("R6", 0, 1, 0);
    drive(0, 0, 1, 0);

    // R8 deselect while paused
    p0 = pulses;
    drive(0, 0, 0, 0);
    outs("R8", 1, 0, 0);
    drive(1, 0, 0, 0);
    outs("R8", 0, 0, 1);
    check("R8", "pulse count", pulses - p0, 1);
    check("R8", "pulse width", last_len, RST_PULSE_CYC);

    // R9 lockout release rules
    drive(0, 0, 0, 0);
    outs("R9", 0, 0, 1);
    drive(0, 0, 1, 0);
    outs("R9", 0, 0, 1);
    drive(1, 0, 1, 0);
    outs("R9", 0, 0, 0);
    drive(0, 0, 1, 0);
    outs("R9", 0, 1, 0);

    // R10 deselect while entry pending
    p0 = pulses;
    drive(0, 1, 0, 0);
    drive(1, 1, 0, 0);
    outs("R10", 0, 0, 0);
    check("R10", "pulse count", pulses - p0, 0);
    drive(1, 0, 1, 0);

    // random phase against settled model
    void'($urandom(32'h5EED_0042));
    model_mode = M_IDLE;
    model_pulses = pulses;
    for (int n = 0; n < 400; n++) begin
      logic c, s, p, q;
      c = ($urandom % 4) == 0;
      s = $urandom % 2;
      p = $urandom % 2;
      q = ($urandom % 7) == 0;
      drive(c, s, p, q);
      model_settle();
      outs("R2/R3/R5/R6/R8/R9 random", model_mode == M_HELD, model_mode == M_RUN,
           model_mode == M_LOCK);
      check("R8/R10 random", "pulse count", pulses, model_pulses);
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end
endmodule